// File: doc/BRIEF.md
# Accumulator Readout Converter

This block turns a 64-bit multiply-accumulate sum into a 32-bit register value. The caller picks one of three readout kinds: a fractional readout, a signed integer readout or an unsigned integer readout. For the fractional kind, three mode bits shape the result. The narrow-mode bit keeps a 16-bit field with its own rounding. The round-enable bit rounds away the low byte. The overflow-mode bit replaces out-of-range results with an extreme value instead of wrapping.

The conversion logic is combinational. A single register stage captures the result together with a valid flag. A request presented in one cycle therefore appears on the outputs after the next rising edge. The block holds no accumulator storage and contains no multiplier; it only reads out the value it is given.

Readout kind encoding on `rd_type`: 0 = fractional, 1 = signed integer, 2 = unsigned integer, 3 = reserved.

Top module: `acc_readout`

## Requirements
- R1: `res_valid` is 0 out of reset and afterwards equals `req_valid` of the previous cycle; `res_data` is 0 out of reset.
- R2: In a cycle without `req_valid`, the inputs are ignored and `res_data` keeps its previous value.
- R3: Fractional readout with `mode_su`=1 keeps accumulator bits 39..24 as an unsigned 16-bit value. The remainder is bits 23..0. The value is incremented when the remainder is above 0x800000, or when it equals 0x800000 and the kept value is odd. The result is zero-extended, so `res_data[31:16]` is 0.
- R4: Fractional readout with `mode_su`=0 and `mode_rt`=1 shifts the accumulator right by 8 as a signed value. The remainder is bits 7..0. The value is incremented when the remainder is above 0x80, or when it equals 0x80 and the shifted value is odd.
- R5: Fractional readout with `mode_su`=0 and `mode_rt`=0 returns the accumulator shifted right by 8 with no rounding, low 32 bits kept.
- R6: With `mode_su`=1 and `mode_omc`=1, a rounded value that no longer fits in 16 bits (0x10000) gives 0x00007FFF.
- R7: With `mode_su`=0 and `mode_omc`=1, a shifted and rounded value outside the signed 32-bit range gives 0x7FFFFFFF if positive and 0x80000000 if negative. In-range values pass unchanged.
- R8: With `mode_omc`=0, the fractional result is truncated: to its low 16 bits (zero-extended) in narrow mode, or to its low 32 bits otherwise.
- R9: Signed readout returns the low 32 bits if the accumulator fits a signed 32-bit word. Otherwise it returns 0x7FFFFFFF for a positive accumulator and 0x80000000 for a negative one.
- R10: Unsigned readout returns the low 32 bits when bits 63..32 are all zero, and 0xFFFFFFFF otherwise.
- R11: Readout kind 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Conversion request this cycle |
| acc_val | input | 64 | Accumulator value to read out |
| rd_type | input | 2 | Readout kind (0 frac, 1 signed, 2 unsigned, 3 reserved) |
| mode_su | input | 1 | Narrow 16-bit fractional mode |
| mode_rt | input | 1 | Round-enable for the 32-bit fractional path |
| mode_omc | input | 1 | Saturate instead of truncate in fractional readout |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_data | output | 32 | Converted result |

## Verification
Some properties are checked on every cycle: the one-cycle valid latency, that the result holds in idle cycles, and that the narrow-mode upper half is zero. The per-cycle checks also cover the saturated extremes of the signed and unsigned integer readouts and the zero result for the reserved kind. Only the bench scenarios can show the fractional rounding. These include half-to-even at exact ties in both paths, the carry out of the 16-bit field that the overflow mode clamps, and the signed clamp of the 32-bit fractional path. The bench compares each of these against a model that is written independently of the RTL.

// File: rtl/acc_rd_pkg.sv
package acc_rd_pkg;

  typedef enum logic [1:0] {
    RD_FRAC     = 2'd0,
    RD_SIGNED   = 2'd1,
    RD_UNSIGNED = 2'd2,
    RD_RESV     = 2'd3
  } rd_kind_e;

  // Round-half-to-even increment decision.
  function automatic logic half_even_up(input logic above, input logic tie, input logic lsb);
    return above | (tie & lsb);
  endfunction

endpackage

// File: rtl/acc_frac_round.sv
module acc_frac_round
  import acc_rd_pkg::*;
#(
  parameter int ACC_W        = 64,
  parameter int NARROW_W     = 16,
  parameter int NARROW_SHIFT = 24,
  parameter int FINE_SHIFT   = 8,
  parameter int WIDE_W       = ACC_W - FINE_SHIFT + 1
) (
  input  logic [ACC_W-1:0]    acc,
  input  logic                rt_en,
  output logic [NARROW_W:0]   narrow_sum,
  output logic [WIDE_W-1:0]   wide_sum
);

  localparam int NARROW_TOP = NARROW_SHIFT + NARROW_W - 1;
  localparam logic [NARROW_SHIFT-1:0] N_HALF = {1'b1, {(NARROW_SHIFT-1){1'b0}}};
  localparam logic [FINE_SHIFT-1:0]   W_HALF = {1'b1, {(FINE_SHIFT-1){1'b0}}};

  logic [NARROW_W-1:0]       n_kept;
  logic [NARROW_SHIFT-1:0]   n_rem;
  logic                      n_up;
  logic [ACC_W-FINE_SHIFT-1:0] w_kept;
  logic [FINE_SHIFT-1:0]     w_rem;
  logic                      w_up;

  // Narrow path: unsigned 16-bit field above a 24-bit remainder.
  assign n_kept = acc[NARROW_TOP:NARROW_SHIFT];
  assign n_rem  = acc[NARROW_SHIFT-1:0];
  assign n_up   = half_even_up(n_rem > N_HALF, n_rem == N_HALF, n_kept[0]);
  assign narrow_sum = {1'b0, n_kept} + {{NARROW_W{1'b0}}, n_up};

  // Wide path: arithmetic shift by FINE_SHIFT, optional rounding.
  assign w_kept = acc[ACC_W-1:FINE_SHIFT];
  assign w_rem  = acc[FINE_SHIFT-1:0];
  assign w_up   = rt_en & half_even_up(w_rem > W_HALF, w_rem == W_HALF, w_kept[0]);
  assign wide_sum = {acc[ACC_W-1], w_kept} + {{(WIDE_W-1){1'b0}}, w_up};

endmodule

// File: rtl/acc_frac_clamp.sv
module acc_frac_clamp #(
  parameter int NARROW_W = 16,
  parameter int RES_W    = 32,
  parameter int WIDE_W   = 57
) (
  input  logic [NARROW_W:0]  narrow_sum,
  input  logic [WIDE_W-1:0]  wide_sum,
  input  logic               su_en,
  input  logic               omc_en,
  output logic [RES_W-1:0]   frac_res
);

  localparam int EXT_W = WIDE_W - RES_W + 1;

  function automatic logic [RES_W-1:0] narrow_out(input logic [NARROW_W:0] s, input logic omc);
    logic [NARROW_W-1:0] pos_max;
    pos_max = {1'b0, {(NARROW_W-1){1'b1}}};
    if (omc && s[NARROW_W]) return RES_W'(pos_max);
    return RES_W'(s[NARROW_W-1:0]);
  endfunction

  function automatic logic [RES_W-1:0] wide_out(input logic [WIDE_W-1:0] s, input logic omc);
    logic [EXT_W-1:0] ext;
    logic             fits;
    logic             neg;
    ext  = s[WIDE_W-1:RES_W-1];
    fits = (&ext) | ~(|ext);
    neg  = s[WIDE_W-1];
    if (omc && !fits) return {neg, {(RES_W-1){~neg}}};
    return s[RES_W-1:0];
  endfunction

  always_comb begin
    if (su_en) frac_res = narrow_out(narrow_sum, omc_en);
    else       frac_res = wide_out(wide_sum, omc_en);
  end

endmodule

// File: rtl/acc_int_read.sv
module acc_int_read #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             signed_sel,
  output logic [RES_W-1:0] int_res
);

  localparam int SGN_EXT_W = ACC_W - RES_W + 1;

  function automatic logic [RES_W-1:0] signed_out(input logic [ACC_W-1:0] a);
    logic [SGN_EXT_W-1:0] ext;
    logic                 neg;
    ext = a[ACC_W-1:RES_W-1];
    neg = a[ACC_W-1];
    if ((&ext) | ~(|ext)) return a[RES_W-1:0];
    return {neg, {(RES_W-1){~neg}}};
  endfunction

  function automatic logic [RES_W-1:0] unsigned_out(input logic [ACC_W-1:0] a);
    if (~(|a[ACC_W-1:RES_W])) return a[RES_W-1:0];
    return {RES_W{1'b1}};
  endfunction

  always_comb begin
    if (signed_sel) int_res = signed_out(acc);
    else            int_res = unsigned_out(acc);
  end

endmodule

// File: rtl/acc_readout.sv
module acc_readout
  import acc_rd_pkg::*;
#(
  parameter int ACC_W        = 64,
  parameter int RES_W        = 32,
  parameter int NARROW_W     = 16,
  parameter int NARROW_SHIFT = 24,
  parameter int FINE_SHIFT   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ACC_W-1:0] acc_val,
  input  logic [1:0]       rd_type,
  input  logic             mode_su,
  input  logic             mode_rt,
  input  logic             mode_omc,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data
);

  localparam int WIDE_W = ACC_W - FINE_SHIFT + 1;

  rd_kind_e           kind;
  logic [NARROW_W:0]  narrow_sum;
  logic [WIDE_W-1:0]  wide_sum;
  logic [RES_W-1:0]   frac_res;
  logic [RES_W-1:0]   int_res;
  logic [RES_W-1:0]   next_res;

  assign kind = rd_kind_e'(rd_type);

  acc_frac_round #(
    .ACC_W(ACC_W), .NARROW_W(NARROW_W), .NARROW_SHIFT(NARROW_SHIFT),
    .FINE_SHIFT(FINE_SHIFT), .WIDE_W(WIDE_W)
  ) u_round (
    .acc(acc_val), .rt_en(mode_rt),
    .narrow_sum(narrow_sum), .wide_sum(wide_sum)
  );

  acc_frac_clamp #(
    .NARROW_W(NARROW_W), .RES_W(RES_W), .WIDE_W(WIDE_W)
  ) u_clamp (
    .narrow_sum(narrow_sum), .wide_sum(wide_sum),
    .su_en(mode_su), .omc_en(mode_omc), .frac_res(frac_res)
  );

  acc_int_read #(
    .ACC_W(ACC_W), .RES_W(RES_W)
  ) u_int (
    .acc(acc_val), .signed_sel(kind == RD_SIGNED), .int_res(int_res)
  );

  always_comb begin
    unique case (kind)
      RD_FRAC:     next_res = frac_res;
      RD_SIGNED,
      RD_UNSIGNED: next_res = int_res;
      default:     next_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) res_data <= next_res;
    end
  end

endmodule

// File: rtl/acc_readout_chk.sv
module acc_readout_chk #(
  parameter int ACC_W    = 64,
  parameter int RES_W    = 32,
  parameter int NARROW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [ACC_W-1:0] acc_val,
  input logic [1:0]       rd_type,
  input logic             mode_su,
  input logic             res_valid,
  input logic [RES_W-1:0] res_data
);

  logic sgn_fits;
  logic uns_over;
  assign sgn_fits = (&acc_val[ACC_W-1:RES_W-1]) | ~(|acc_val[ACC_W-1:RES_W-1]);
  assign uns_over = |acc_val[ACC_W-1:RES_W];

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(res_data));

  p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rd_type == 2'd0 && mode_su) |=> (res_data[RES_W-1:NARROW_W] == '0));

  p_signed_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rd_type == 2'd1 && !sgn_fits) |=>
      (res_data == {$past(acc_val[ACC_W-1]), {(RES_W-1){~$past(acc_val[ACC_W-1])}}}));

  p_unsigned_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rd_type == 2'd2 && uns_over) |=> (&res_data));

  p_resv_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rd_type == 2'd3) |=> (res_data == '0));

endmodule

bind acc_readout acc_readout_chk #(
  .ACC_W(ACC_W), .RES_W(RES_W), .NARROW_W(NARROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_val(acc_val),
  .rd_type(rd_type), .mode_su(mode_su), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/acc_readout_tb.sv
module acc_readout_tb;

  localparam longint S32_HI = 64'sd2147483647;
  localparam longint S32_LO = -64'sd2147483648;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] acc_val = '0;
  logic [1:0]  rd_type = '0;
  logic        mode_su = 1'b0;
  logic        mode_rt = 1'b0;
  logic        mode_omc = 1'b0;
  logic        res_valid;
  logic [31:0] res_data;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t    sb_q[$];
  int          n_checks = 0;
  int          n_fail = 0;
  logic [31:0] last_data = '0;
  logic        mon_on = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  acc_readout u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_val(acc_val),
    .rd_type(rd_type), .mode_su(mode_su), .mode_rt(mode_rt), .mode_omc(mode_omc),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [31:0] model(input logic [63:0] a, input logic [1:0] k,
                                        input logic su, input logic rt, input logic omc);
    longint      s;
    logic [63:0] q;
    logic [63:0] rem;
    case (k)
      2'd0: begin
        if (su) begin
          q   = (a >> 24) & 64'hFFFF;
          rem = a & 64'hFF_FFFF;
          if (rem > 64'h80_0000) q = q + 1;
          else if (rem == 64'h80_0000) q = q + (q & 1);
          if (omc && q > 64'hFFFF) return 32'h0000_7FFF;
          return {16'h0, q[15:0]};
        end
        s = $signed(a) >>> 8;
        if (rt) begin
          rem = a & 64'hFF;
          if (rem > 64'h80) s = s + 1;
          else if (rem == 64'h80) s = s + (s & 1);
        end
        if (omc && (s > S32_HI || s < S32_LO)) return (s < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        return s[31:0];
      end
      2'd1: begin
        s = $signed(a);
        if (s > S32_HI || s < S32_LO) return (s < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        return a[31:0];
      end
      2'd2: return ((a >> 32) == 0) ? a[31:0] : 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [63:0] next_rand(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic send(input logic [63:0] a, input logic [1:0] k, input logic su,
                      input logic rt, input logic omc, input string tag);
    sb_item_t it;
    @(negedge clk);
    acc_val   = a;
    rd_type   = k;
    mode_su   = su;
    mode_rt   = rt;
    mode_omc  = omc;
    req_valid = 1'b1;
    it.exp = model(a, k, su, rt, omc);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      seed      = next_rand(seed);
      acc_val   = seed;
      rd_type   = seed[1:0];
      mode_su   = seed[2];
      mode_rt   = seed[3];
      mode_omc  = seed[4];
    end
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per valid result; idle cycles must hold (R2).
  always @(negedge clk) begin
    if (mon_on) begin
      if (res_valid === 1'b1) begin
        if (sb_q.size() == 0) begin
          check(32'h1, 32'h0, "R1 unexpected valid");
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          check(res_data, it.exp, it.tag);
        end
        last_data = res_data;
      end else begin
        check(res_data, last_data, "R2 hold while idle");
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({31'h0, res_valid}, 32'h0, "R1 reset valid");
    check(res_data, 32'h0, "R1 reset data");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R3 narrow rounding
    send(64'h0000_0012_3480_0000, 2'd0, 1'b1, 1'b0, 1'b0, "R3 tie even");
    send(64'h0000_0012_3580_0000, 2'd0, 1'b1, 1'b0, 1'b0, "R3 tie odd");
    send(64'h0000_0012_3480_0001, 2'd0, 1'b1, 1'b0, 1'b0, "R3 above half");
    send(64'hFFFF_FF12_347F_FFFF, 2'd0, 1'b1, 1'b0, 1'b1, "R3 below half high bits");
    idle(2);
    // R6 / R8 narrow carry
    send(64'h0000_00FF_FF90_0000, 2'd0, 1'b1, 1'b0, 1'b1, "R6 narrow clamp");
    send(64'h0000_00FF_FF90_0000, 2'd0, 1'b1, 1'b0, 1'b0, "R8 narrow wrap");
    // R4 rounding
    send(64'h0000_0000_1234_5680, 2'd0, 1'b0, 1'b1, 1'b0, "R4 tie even");
    send(64'h0000_0000_1234_5780, 2'd0, 1'b0, 1'b1, 1'b0, "R4 tie odd");
    send(64'h0000_0000_1234_5681, 2'd0, 1'b0, 1'b1, 1'b0, "R4 above half");
    send(64'hFFFF_FFFF_FFFF_FF80, 2'd0, 1'b0, 1'b1, 1'b0, "R4 negative tie");
    idle(1);
    // R5 truncation shift
    send(64'h0000_0000_1234_56FF, 2'd0, 1'b0, 1'b0, 1'b0, "R5 no round");
    // R7 wide clamp
    send(64'h0000_0100_0000_0000, 2'd0, 1'b0, 1'b0, 1'b1, "R7 positive clamp");
    send(64'hFFFF_FF00_0000_0000, 2'd0, 1'b0, 1'b0, 1'b1, "R7 negative clamp");
    send(64'hFFFF_FFFF_FF00_0000, 2'd0, 1'b0, 1'b0, 1'b1, "R7 in range");
    send(64'h0000_007F_FFFF_FFFF, 2'd0, 1'b0, 1'b1, 1'b1, "R7 round past max");
    // R8 wide truncation
    send(64'h0000_0100_0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, "R8 wide wrap");
    idle(3);
    // R9 signed
    send(64'h0000_0000_7FFF_FFFF, 2'd1, 1'b0, 1'b0, 1'b0, "R9 max fits");
    send(64'h0000_0000_8000_0000, 2'd1, 1'b1, 1'b1, 1'b1, "R9 positive sat");
    send(64'hFFFF_FFFF_8000_0000, 2'd1, 1'b0, 1'b0, 1'b0, "R9 min fits");
    send(64'h8000_0000_0000_0000, 2'd1, 1'b0, 1'b0, 1'b0, "R9 negative sat");
    // R10 unsigned
    send(64'h0000_0000_DEAD_BEEF, 2'd2, 1'b0, 1'b0, 1'b0, "R10 fits");
    send(64'h0000_0001_0000_0000, 2'd2, 1'b1, 1'b0, 1'b1, "R10 sat");
    // R11 reserved
    send(64'h1234_5678_9ABC_DEF0, 2'd3, 1'b0, 1'b1, 1'b0, "R11 reserved");
    idle(2);

    // Random mix with gaps (R1 latency, R2 hold between)
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      seed = next_rand(seed);
      a = seed;
      if (seed[7:5] == 3'd0) a[23:0] = 24'h80_0000;
      if (seed[7:5] == 3'd1) a[7:0]  = 8'h80;
      if (seed[10:8] == 3'd2) a[63:40] = {24{a[39]}};
      send(a, seed[12:11], seed[13], seed[14], seed[15],
           (seed[12:11] == 2'd0) ? "R3 R4 R5 R6 R7 R8 random frac" :
           (seed[12:11] == 2'd1) ? "R9 random signed" :
           (seed[12:11] == 2'd2) ? "R10 random unsigned" : "R11 random reserved");
      if (seed[20:18] == 3'd0) idle(int'(seed[22:21]) + 1);
    end

    idle(4);
    check(32'(sb_q.size()), 32'h0, "R1 all results delivered");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule